// File: doc/BRIEF.md
# Dual-Channel Snapshot Sample Buffer

This block takes two 8-bit sample streams that arrive together in a 60 MHz converter clock domain and records them into two separate buffers, one per channel. A programmable divider turns the 60 MHz clock into a one-cycle write enable, so the same sampling moment lands in both buffers at the same address. The divider is a clock-enable, not a derived clock, and the divide ratio is a power of two from 1 to 1024.

Each capture is a one-shot snapshot. An arm pulse empties both buffers and starts writing. Writing stops once the configured depth has been stored, and a done flag is raised. A slow host bus then drains each buffer in order. The host reads with a level strobe that is much slower than the clock. The block detects the strobe's rising edge, and each qualified edge pops one entry from the selected channel onto a registered data output. Full and empty flags per channel tell the host where it stands.

Top module: `dual_snap_buffer`

## Requirements
- R1: After reset both buffers are empty, neither is full, `busy` and `done` are low, and `rd_data` is zero.
- R2: A high `arm` while `busy` is low empties both buffers in that clock edge, even if unread entries remain. The same edge raises `busy` and latches `rate_sel`.
- R3: While busy, a sample pair is written every 2^`rate_sel` clock edges. Codes above 10 act as 10, so the period is 1024 edges. The first write happens on the 2^code-th edge after the arm edge.
- R4: Each write stores `smp_a` in the A buffer and `smp_b` in the B buffer, both taken at the same clock edge and placed at the same position in order.
- R5: After DEPTH writes, no further samples are stored. On the edge of the last write, `busy` falls and `done` rises.
- R6: `done` stays high, whatever reads take place, until the next accepted arm, which clears it.
- R7: A read pops one entry. It takes place at the clock edge where `rd_stb` is first seen high after being low, with `rd_en` high and the selected buffer not empty. `rd_chan` 0 selects A and 1 selects B. The oldest entry of that channel appears on `rd_data` after that edge.
- R8: A read is not performed, and `rd_data` holds, in three cases: `rd_stb` is held high past its first edge, `rd_en` is low, or the selected buffer is empty.
- R9: While `busy` is high, changes on `rate_sel` and pulses on `arm` have no effect on the capture in progress.
- R10: A channel's full flag is high exactly when it holds DEPTH unread entries. Its empty flag is high exactly when it holds none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new snapshot (honoured only when idle) |
| rate_sel | input | 4 | Divide code: period is 2^code clocks, clipped at 10 |
| smp_a | input | 8 | Channel A converter sample |
| smp_b | input | 8 | Channel B converter sample |
| rd_stb | input | 1 | Host read strobe, level from the slow bus |
| rd_en | input | 1 | Host read enable |
| rd_chan | input | 1 | Host channel select, 0 = A, 1 = B |
| rd_data | output | 8 | Last popped sample |
| full_a | output | 1 | Channel A buffer holds DEPTH entries |
| full_b | output | 1 | Channel B buffer holds DEPTH entries |
| empty_a | output | 1 | Channel A buffer holds no entries |
| empty_b | output | 1 | Channel B buffer holds no entries |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Snapshot complete, sticky until the next arm |

## Verification
The bench runs three snapshots. The first uses the undivided rate, which exposes off-by-one errors at the first write and at the stop point. The second uses ratio 8 and changes the rate code and pulses arm mid-capture, which shows whether the running divider and sequence are really protected. The third uses an out-of-range code, which separates correct clipping to 1024 from wraparound. The channel samples follow different per-edge formulas, so swapped channels, a skewed strobe or a wrong ratio all give mismatching popped values. Reads are issued channel-by-channel, interleaved, with a held strobe, with enable low and on an empty buffer. This separates single-pop edge detection and per-channel pointers from looser variants.

// File: rtl/dual_snap_buffer.sv
module dual_snap_buffer #(
  parameter int DW        = 8,
  parameter int DEPTH     = 512,
  parameter int SEL_W     = 4,
  parameter int MAX_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic [DW-1:0]    smp_a,
  input  logic [DW-1:0]    smp_b,
  input  logic             rd_stb,
  input  logic             rd_en,
  input  logic             rd_chan,
  output logic [DW-1:0]    rd_data,
  output logic             full_a,
  output logic             full_b,
  output logic             empty_a,
  output logic             empty_b,
  output logic             busy,
  output logic             done
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int DCW = MAX_SHIFT + 1;

  logic [SEL_W-1:0] rate_q;
  logic [SEL_W-1:0] shift_eff;
  logic [DCW-1:0]   div_cnt, div_lim;
  logic [CW-1:0]    wptr, rp_a, rp_b;
  logic             stb_q;
  logic [DW-1:0]    mem_a [DEPTH];
  logic [DW-1:0]    mem_b [DEPTH];

  assign shift_eff = (rate_q > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : rate_q;
  assign div_lim   = (DCW'(1) << shift_eff) - DCW'(1);

  wire start  = arm && !busy;
  wire tick   = busy && (div_cnt == div_lim);
  wire fire   = rd_stb && !stb_q && rd_en && !start;
  wire pop_a  = fire && !rd_chan && !empty_a;
  wire pop_b  = fire &&  rd_chan && !empty_b;

  assign empty_a = (rp_a == wptr);
  assign empty_b = (rp_b == wptr);
  assign full_a  = ((wptr - rp_a) == CW'(DEPTH));
  assign full_b  = ((wptr - rp_b) == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rate_q  <= '0;
      div_cnt <= '0;
      wptr    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      rate_q  <= rate_sel;
      div_cnt <= '0;
      wptr    <= '0;
    end else if (busy) begin
      if (tick) begin
        div_cnt <= '0;
        wptr    <= wptr + CW'(1);
        if (wptr == CW'(DEPTH - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + DCW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tick) begin
      mem_a[wptr[AW-1:0]] <= smp_a;
      mem_b[wptr[AW-1:0]] <= smp_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_a    <= '0;
      rp_b    <= '0;
      stb_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      stb_q <= rd_stb;
      if (start) begin
        rp_a <= '0;
        rp_b <= '0;
      end else if (pop_a) begin
        rp_a    <= rp_a + CW'(1);
        rd_data <= mem_a[rp_a[AW-1:0]];
      end else if (pop_b) begin
        rp_b    <= rp_b + CW'(1);
        rd_data <= mem_b[rp_b[AW-1:0]];
      end
    end
  end
endmodule

// File: rtl/dual_snap_buffer_chk.sv
module dual_snap_buffer_chk #(
  parameter int DW    = 8,
  parameter int SEL_W = 4,
  parameter int CW    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             busy,
  input logic             done,
  input logic             empty_a,
  input logic             empty_b,
  input logic             full_a,
  input logic             full_b,
  input logic             rd_stb,
  input logic             rd_en,
  input logic             stb_q,
  input logic [DW-1:0]    rd_data,
  input logic [SEL_W-1:0] rate_q,
  input logic [CW-1:0]    wptr
);
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_a && empty_a) && !(full_b && empty_b));

  assert_busy_done_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_no_write_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> $stable(wptr));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !busy) |=> (busy && empty_a && empty_b && !done));

  assert_rate_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rate_q));

  assert_no_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || !rd_stb || stb_q) |=> $stable(rd_data));
endmodule

bind dual_snap_buffer dual_snap_buffer_chk #(.DW(DW), .SEL_W(SEL_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .busy(busy), .done(done),
  .empty_a(empty_a), .empty_b(empty_b), .full_a(full_a), .full_b(full_b),
  .rd_stb(rd_stb), .rd_en(rd_en), .stb_q(stb_q), .rd_data(rd_data),
  .rate_q(rate_q), .wptr(wptr)
);

// File: tb/dual_snap_buffer_tb.sv
module dual_snap_buffer_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n, arm, rd_stb, rd_en, rd_chan;
  logic [3:0] rate_sel;
  logic [7:0] smp_a, smp_b, rd_data;
  logic       full_a, full_b, empty_a, empty_b, busy, done;

  dual_snap_buffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rate_sel(rate_sel),
    .smp_a(smp_a), .smp_b(smp_b), .rd_stb(rd_stb), .rd_en(rd_en),
    .rd_chan(rd_chan), .rd_data(rd_data), .full_a(full_a), .full_b(full_b),
    .empty_a(empty_a), .empty_b(empty_b), .busy(busy), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [7:0] qa[$];
  logic [7:0] qb[$];
  logic mon_req = 1'b0;
  logic mon_ch  = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic capture(input int code, input int seed, input bit poke);
    int sh, r, pushed;
    sh = (code > 10) ? 10 : code;
    r = 1 << sh;
    pushed = 0;
    qa.delete();
    qb.delete();
    @(negedge clk);
    rate_sel = 4'(code);
    arm = 1'b1;
    for (int j = 1; j <= DEPTH*r + 3*r; j++) begin
      @(negedge clk);
      arm = poke && (j == 3);
      if (poke && j == 2) rate_sel = 4'd0;
      if (j == 1) begin
        check(busy == 1'b1, "R2 busy after arm", busy, 1);
        check(empty_a && empty_b, "R2 buffers cleared by arm", {empty_a, empty_b}, 3);
        check(done == 1'b0, "R6 done cleared by arm", done, 0);
      end
      if (j == r)     check(empty_a == 1'b1, "R3 no write before first strobe", empty_a, 1);
      if (j == r + 1) check(empty_a == 1'b0, "R3 first write on strobe", empty_a, 0);
      smp_a = 8'(j*13 + seed);
      smp_b = 8'(j*29 + seed*3 + 1);
      if ((j % r) == 0 && pushed < DEPTH) begin
        qa.push_back(smp_a);
        qb.push_back(smp_b);
        pushed++;
      end
    end
    arm = 1'b0;
    check(done && !busy, "R5 done set and busy clear after DEPTH writes", {done, busy}, 2);
    check(full_a && full_b, "R10 both full after capture", {full_a, full_b}, 3);
  endtask

  task automatic read_one(input logic ch);
    @(negedge clk);
    rd_chan = ch;
    rd_en   = 1'b1;
    rd_stb  = 1'b1;
    mon_ch  = ch;
    mon_req = 1'b1;
    @(negedge clk);
    rd_stb  = 1'b0;
  endtask

  initial begin
    logic ch;
    logic [7:0] e;
    forever begin
      @(posedge clk);
      if (mon_req) begin
        ch = mon_ch;
        mon_req = 1'b0;
        @(negedge clk);
        if (ch == 1'b0) begin
          if (qa.size() == 0) check(1'b0, "R7 unexpected pop on A", rd_data, -1);
          else begin
            e = qa.pop_front();
            check(rd_data == e, "R7 R4 channel A popped value", rd_data, e);
          end
        end else begin
          if (qb.size() == 0) check(1'b0, "R7 unexpected pop on B", rd_data, -1);
          else begin
            e = qb.pop_front();
            check(rd_data == e, "R7 R4 channel B popped value", rd_data, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    rst_n = 1'b0; arm = 1'b0; rd_stb = 1'b0; rd_en = 1'b0; rd_chan = 1'b0;
    rate_sel = '0; smp_a = '0; smp_b = '0;
    repeat (3) @(negedge clk);
    check(empty_a && empty_b && !full_a && !full_b, "R1 reset flags",
          {empty_a, empty_b, full_a, full_b}, 12);
    check(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    check(rd_data == 8'd0, "R1 reset rd_data", rd_data, 0);
    rst_n = 1'b1;

    capture(0, 5, 1'b0);
    read_one(1'b0);
    @(negedge clk);
    check(!full_a && full_b, "R10 full drops per channel", {full_a, full_b}, 1);
    for (int i = 1; i < DEPTH; i++) read_one(1'b0);
    @(negedge clk);
    check(empty_a && !empty_b, "R10 A empty, B not", {empty_a, empty_b}, 2);
    check(done == 1'b1, "R6 done holds during reads", done, 1);
    hold = rd_data;
    rd_chan = 1'b0; rd_en = 1'b1; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    @(negedge clk);
    check(rd_data == hold, "R8 read on empty holds data", rd_data, hold);
    for (int i = 0; i < DEPTH; i++) read_one(1'b1);
    @(negedge clk);
    check(empty_b && qa.size() == 0 && qb.size() == 0, "R5 exactly DEPTH entries stored",
          qa.size() + qb.size(), 0);

    capture(3, 40, 1'b1);
    hold = rd_data;
    @(negedge clk); rd_en = 1'b0; rd_chan = 1'b0; rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    @(negedge clk);
    check(rd_data == hold, "R8 rd_en low holds data", rd_data, hold);
    check(full_a == 1'b1, "R8 rd_en low pops nothing", full_a, 1);
    rd_en = 1'b1; rd_chan = 1'b0; rd_stb = 1'b1; mon_ch = 1'b0; mon_req = 1'b1;
    @(negedge clk);
    hold = rd_data;
    repeat (3) @(negedge clk);
    check(rd_data == hold, "R8 held strobe pops once", rd_data, hold);
    rd_stb = 1'b0;
    for (int i = 0; i < DEPTH/2 - 1; i++) read_one(1'b0);
    for (int i = 0; i < DEPTH/2; i++) read_one(1'b1);
    @(negedge clk);
    check(done == 1'b1, "R6 done holds with entries left", done, 1);

    capture(15, 90, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      read_one(1'b0);
      read_one(1'b1);
    end
    @(negedge clk);
    check(empty_a && empty_b, "R10 both empty after full drain", {empty_a, empty_b}, 3);
    check(qa.size() == 0 && qb.size() == 0, "R3 clipped ratio entries all read",
          qa.size() + qb.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule